// File: doc/BRIEF.md
# Edge-Preserving Bilateral Smoothing Filter

This block cleans noise from a grayscale image stream before stereo correspondence. Pixels enter in raster order and leave in raster order with the same frame size. Each output is a weighted mean of the 5x5 neighbourhood around the pixel. A neighbour's weight is the product of two Gaussians: one on its spatial distance from the centre, one on its intensity difference from the centre. Neighbours across a strong edge therefore get almost no weight, and the edge stays sharp while flat regions are smoothed.

Both streams use valid/ready. An input pixel transfers on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` does not depend on `in_valid`. It falls in three cases: while a normalization division runs, while a line slot still holds rows needed by pending outputs, and after the last pixel of a frame until that frame's final window has been taken. An output transfers when `out_valid` and `out_ready` are both high. While `out_ready` is low, the output pixel is held. Frames follow one another with no gap signal. The pixel count (`IMG_W*IMG_H`) marks the frame boundary.

Top module: `bilat_filter`

## Requirements
- R1: An input pixel is taken only on a clock edge with `in_valid` and `in_ready` both high. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_pixel` does not change.
- R2: `in_ready` is low in every cycle of a normalization division, so it is low in the cycle before each rise of `out_valid`.
- R3: For every `IMG_W*IMG_H` input pixels, exactly `IMG_W*IMG_H` outputs appear in raster order, and no further output appears until more input arrives. Frames can follow back to back.
- R4: A frame where every pixel has the same value V produces V at every position, for any V in 0..255.
- R5: A frame split by a vertical or horizontal step of 100 codes or more gives outputs within one code of the input value on each side of the step, including right at the step.
- R6: Every output lies between the minimum and maximum of its (border-replicated) 5x5 neighbourhood.
- R7: At the image borders, window positions outside the frame take the value of the nearest in-frame pixel, in the same row or column. The output frame has the input's dimensions.
- R8: Each output is within one code of round(sum(w*p)/sum(w)) over the 25 taps. Here w = exp(-(dx^2+dy^2)/(2*1.5^2)) * exp(-d^2/(2*12.75^2)), where d is the absolute difference from the centre pixel. 12.75 equals 0.05 of the full 8-bit scale. Both factors are stored as unsigned 16-bit fractions. A large range sigma (`SIGMA_R_MILLI`) reduces the filter to a plain Gaussian blur.
- R9: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can take an input pixel |
| in_pixel | input | 8 | Input grayscale pixel, raster order |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Downstream takes the output pixel |
| out_pixel | output | 8 | Filtered pixel, raster order |

## Verification
The assertions check on every cycle that:
- a stalled output holds its value;
- no input is accepted while the divider is busy;
- the divider starts only when idle, with a denominator at least the centre tap's weight;
- every quotient falls inside the min/max of the captured window.

Only the bench scenarios can show:
- that flat frames pass unchanged and step edges survive;
- that border replication and weighting match the Gaussian definition;
- that frames keep raster order and exact length under random gaps on both streams.

// File: rtl/bf_pkg.sv
package bf_pkg;
  localparam int PIX_W  = 8;
  localparam int WIN    = 5;
  localparam int RAD    = WIN / 2;
  localparam int TAPS   = WIN * WIN;
  localparam int CTR    = TAPS / 2;
  localparam int WT_W   = 16;
  localparam int LEVELS = 1 << PIX_W;
  localparam int ACC_W  = PIX_W + WT_W + $clog2(TAPS) + 1;
  localparam int DEN_W  = WT_W + $clog2(TAPS) + 1;

  typedef logic [PIX_W-1:0] pix_t;

  // Gaussian factor as an unsigned fraction with WT_W bits, full scale ~1.0
  function automatic logic [WT_W-1:0] gauss_q(real dist_sq, real sigma);
    real e;
    e = $exp(-dist_sq / (2.0 * sigma * sigma));
    return WT_W'($rtoi(e * real'((1 << WT_W) - 1) + 0.5));
  endfunction

  function automatic int clampi(int v, int hi);
    if (v < 0) return 0;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/bf_linemem.sv
module bf_linemem
  import bf_pkg::*;
#(
  parameter int IMG_W = 64,
  parameter int IMG_H = 48
) (
  input  logic                       clk,
  input  logic                       wr_en,
  input  logic [$clog2(IMG_H)-1:0]   wr_row,
  input  logic [$clog2(IMG_W)-1:0]   wr_col,
  input  pix_t                       wr_pix,
  input  logic [$clog2(IMG_H)-1:0]   ctr_row,
  input  logic [$clog2(IMG_W)-1:0]   ctr_col,
  output pix_t [TAPS-1:0]            win
);
  localparam int COL_W  = $clog2(IMG_W);
  localparam int SLOT_W = $clog2(WIN);

  // five row slots: four completed lines plus the line being filled
  pix_t mem [WIN][IMG_W];
  logic [SLOT_W-1:0] wr_slot;

  assign wr_slot = SLOT_W'(int'(wr_row) % WIN);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_slot][wr_col] <= wr_pix;
  end

  // clamped (edge-replicated) 5x5 gather around the centre position
  for (genvar ty = 0; ty < WIN; ty++) begin : g_row
    for (genvar tx = 0; tx < WIN; tx++) begin : g_col
      int rr, cc;
      always_comb begin
        rr = clampi(int'(ctr_row) + ty - RAD, IMG_H - 1);
        cc = clampi(int'(ctr_col) + tx - RAD, IMG_W - 1);
      end
      assign win[ty*WIN + tx] = mem[SLOT_W'(rr % WIN)][COL_W'(cc)];
    end
  end
endmodule

// File: rtl/bf_weigh.sv
module bf_weigh
  import bf_pkg::*;
#(
  parameter int SIGMA_S_CENTI = 150,
  parameter int SIGMA_R_MILLI = 50
) (
  input  pix_t [TAPS-1:0]   win,
  output logic [ACC_W-1:0]  num,
  output logic [DEN_W-1:0]  den
);
  localparam real SIG_S = real'(SIGMA_S_CENTI) / 100.0;
  localparam real SIG_R = real'(SIGMA_R_MILLI) * real'(LEVELS - 1) / 1000.0;

  logic [WT_W-1:0] sp_rom [TAPS];
  logic [WT_W-1:0] rg_rom [LEVELS];
  logic [WT_W-1:0] wt     [TAPS];

  for (genvar g = 0; g < TAPS; g++) begin : g_sp
    localparam int DY = g / WIN - RAD;
    localparam int DX = g % WIN - RAD;
    assign sp_rom[g] = gauss_q(real'(DY*DY + DX*DX), SIG_S);
  end

  for (genvar g = 0; g < LEVELS; g++) begin : g_rg
    assign rg_rom[g] = gauss_q(real'(g*g), SIG_R);
  end

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    pix_t dif;
    assign dif   = (win[g] >= win[CTR]) ? win[g] - win[CTR] : win[CTR] - win[g];
    assign wt[g] = WT_W'((32'(sp_rom[g]) * 32'(rg_rom[dif])) >> WT_W);
  end

  always_comb begin
    num = '0;
    den = '0;
    for (int k = 0; k < TAPS; k++) begin
      num = num + ACC_W'(wt[k]) * ACC_W'(win[k]);
      den = den + DEN_W'(wt[k]);
    end
  end
endmodule

// File: rtl/bf_divider.sv
module bf_divider
  import bf_pkg::*;
#(
  parameter int NUM_W = ACC_W,
  parameter int DN_W  = DEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NUM_W-1:0]  num,
  input  logic [DN_W-1:0]   den,
  output logic              busy,
  output logic              done,
  output pix_t              quot
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] n_q, q_q;
  logic [DN_W-1:0]  d_q, rem_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;
  logic [DN_W:0]    trial;
  logic             ge;

  assign trial = {rem_q, n_q[NUM_W-1]};
  assign ge    = trial >= {1'b0, d_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_q <= '0; q_q <= '0; d_q <= '0; rem_q <= '0;
      cnt_q <= '0; busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        n_q    <= num + NUM_W'(den >> 1);   // bias for round-to-nearest
        d_q    <= den;
        rem_q  <= '0;
        q_q    <= '0;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= DN_W'(ge ? trial - {1'b0, d_q} : trial);
        q_q   <= {q_q[NUM_W-2:0], ge};
        n_q   <= n_q << 1;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(NUM_W - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign quot = (|q_q[NUM_W-1:PIX_W]) ? {PIX_W{1'b1}} : q_q[PIX_W-1:0];

  AST_DEN_FLOOR: assert property (@(posedge clk) disable iff (!rst_n) start |-> den >= DN_W'((1 << WT_W) - 2)) else $error("denominator below centre weight"); // R8
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n) start |-> !busy_q) else $error("division restarted while busy"); // R2
endmodule

// File: rtl/bilat_filter.sv
module bilat_filter
  import bf_pkg::*;
#(
  parameter int IMG_W         = 64,
  parameter int IMG_H         = 48,
  parameter int SIGMA_S_CENTI = 150,
  parameter int SIGMA_R_MILLI = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_pixel,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_pixel
);
  localparam int COL_W = $clog2(IMG_W);
  localparam int ROW_W = $clog2(IMG_H);

  typedef enum logic [1:0] {S_IDLE, S_WGT, S_DIV} st_t;

  st_t               state;
  logic [ROW_W-1:0]  in_r, pos_r;
  logic [COL_W-1:0]  in_c, pos_c;
  logic              in_full;
  logic              data_ok, room_ok;
  logic              in_fire, out_fire, launch;
  pix_t [TAPS-1:0]   win_rd, win_q;
  logic [ACC_W-1:0]  num;
  logic [DEN_W-1:0]  den;
  logic              div_start, div_busy, div_done;
  pix_t              quot;
  logic              ov_q;
  pix_t              op_q;

  // flow control: is the next window complete, and may the next input overwrite its slot
  always_comb begin
    int nr, nc, wc;
    nr = clampi(int'(pos_r) + RAD, IMG_H - 1);
    nc = clampi(int'(pos_c) + RAD, IMG_W - 1);
    data_ok = in_full || (int'(in_r) > nr) || (int'(in_r) == nr && int'(in_c) > nc);
    wc = clampi(int'(in_c) + RAD, IMG_W - 1);
    room_ok = (int'(in_r) <= RAD) || (int'(pos_r) > int'(in_r) - RAD - 1) ||
              (int'(pos_r) == int'(in_r) - RAD - 1 && int'(pos_c) > wc);
  end

  assign in_ready  = !in_full && room_ok && (state != S_DIV);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = ov_q && out_ready;
  assign launch    = (state == S_IDLE) && data_ok && !ov_q;
  assign div_start = (state == S_WGT);

  bf_linemem #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_lines (
    .clk     (clk),
    .wr_en   (in_fire),
    .wr_row  (in_r),
    .wr_col  (in_c),
    .wr_pix  (in_pixel),
    .ctr_row (pos_r),
    .ctr_col (pos_c),
    .win     (win_rd)
  );

  bf_weigh #(.SIGMA_S_CENTI(SIGMA_S_CENTI), .SIGMA_R_MILLI(SIGMA_R_MILLI)) u_weigh (
    .win (win_q),
    .num (num),
    .den (den)
  );

  bf_divider #(.NUM_W(ACC_W), .DN_W(DEN_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (num),
    .den   (den),
    .busy  (div_busy),
    .done  (div_done),
    .quot  (quot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      in_r    <= '0;
      in_c    <= '0;
      pos_r   <= '0;
      pos_c   <= '0;
      in_full <= 1'b0;
      win_q   <= '0;
      ov_q    <= 1'b0;
      op_q    <= '0;
    end else begin
      if (in_fire) begin
        if (in_c == COL_W'(IMG_W - 1)) begin
          in_c <= '0;
          if (in_r == ROW_W'(IMG_H - 1)) begin
            in_r    <= '0;
            in_full <= 1'b1;
          end else begin
            in_r <= in_r + 1'b1;
          end
        end else begin
          in_c <= in_c + 1'b1;
        end
      end
      if (out_fire) ov_q <= 1'b0;
      case (state)
        S_IDLE: if (launch) begin
          win_q <= win_rd;
          state <= S_WGT;
          if (pos_c == COL_W'(IMG_W - 1)) begin
            pos_c <= '0;
            if (pos_r == ROW_W'(IMG_H - 1)) begin
              pos_r   <= '0;
              in_full <= 1'b0;
            end else begin
              pos_r <= pos_r + 1'b1;
            end
          end else begin
            pos_c <= pos_c + 1'b1;
          end
        end
        S_WGT: state <= S_DIV;
        S_DIV: if (div_done) begin
          op_q  <= quot;
          ov_q  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign out_valid = ov_q;
  assign out_pixel = op_q;

  // window extremes, used only by the bound check below
  pix_t win_lo, win_hi;
  always_comb begin
    win_lo = '1;
    win_hi = '0;
    for (int k = 0; k < TAPS; k++) begin
      if (win_q[k] < win_lo) win_lo = win_q[k];
      if (win_q[k] > win_hi) win_hi = win_q[k];
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) out_valid && !out_ready |=> out_valid && $stable(out_pixel)) else $error("stalled output changed"); // R1
  AST_DIV_STALL: assert property (@(posedge clk) disable iff (!rst_n) div_busy |-> !in_ready) else $error("input accepted during division"); // R2
  AST_RESULT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) div_done |-> quot >= win_lo && quot <= win_hi) else $error("result outside window range"); // R6
endmodule

// File: tb/sim_bilat_filter.sv
module sim_bilat_filter;
  localparam int W = 12;
  localparam int H = 8;
  localparam int NPIX = W * H;
  localparam int LIMIT = 150000;
  localparam real SIG_S = 1.5;
  localparam real SIG_R = 12.75;

  typedef struct packed {
    logic [2:0] kind;   // 0 flat,1 vstep,2 hstep,3 impulse,4 ramp,5 noise
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] p;
  } vec_t;

  localparam vec_t VECS [0:8] = '{
    '{3'd0, 8'd0,   8'd0,   8'd0},
    '{3'd0, 8'd255, 8'd0,   8'd0},
    '{3'd0, 8'd97,  8'd0,   8'd0},
    '{3'd1, 8'd30,  8'd200, 8'd6},
    '{3'd2, 8'd220, 8'd40,  8'd4},
    '{3'd3, 8'd100, 8'd108, 8'h35},
    '{3'd3, 8'd60,  8'd70,  8'h00},
    '{3'd4, 8'd3,   8'd7,   8'd0},
    '{3'd5, 8'hA5,  8'd120, 8'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_pixel = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [7:0] out_pixel;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit timed_out = 1'b0;
  logic [15:0] lf = 16'hACE1;
  int img [H][W];

  always #2 clk = ~clk;

  bilat_filter #(.IMG_W(W), .IMG_H(H)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_pixel(in_pixel),
    .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel)
  );

  function automatic logic rbit();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf[0];
  endfunction

  function automatic int cl(int v, int hi);
    return (v < 0) ? 0 : (v > hi) ? hi : v;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic fill(input vec_t v);
    logic [15:0] s = {8'h5A, v.a};
    for (int r = 0; r < H; r++) begin
      for (int c = 0; c < W; c++) begin
        case (v.kind)
          3'd0: img[r][c] = v.a;
          3'd1: img[r][c] = (c < int'(v.p)) ? v.a : v.b;
          3'd2: img[r][c] = (r < int'(v.p)) ? v.a : v.b;
          3'd3: img[r][c] = (r == int'(v.p[7:4]) && c == int'(v.p[3:0])) ? v.b : v.a;
          3'd4: img[r][c] = int'(v.a) * c + int'(v.b) * r;
          default: begin
            s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
            img[r][c] = int'(v.b) + int'(s % 16'd21) - 10;
          end
        endcase
      end
    end
  endtask

  // normalized bilateral mean with replicated borders, real arithmetic
  function automatic int ref_px(int r, int c);
    real sw = 0.0, sv = 0.0, w;
    int ctr = img[r][c];
    for (int dy = -2; dy <= 2; dy++)
      for (int dx = -2; dx <= 2; dx++) begin
        int q = img[cl(r + dy, H - 1)][cl(c + dx, W - 1)];
        w = $exp(-real'(dx*dx + dy*dy) / (2.0 * SIG_S * SIG_S)) *
            $exp(-real'((q - ctr) * (q - ctr)) / (2.0 * SIG_R * SIG_R));
        sw += w;
        sv += w * real'(q);
      end
    return $rtoi(sv / sw + 0.5);
  endfunction

  task automatic win_range(input int r, input int c, output int lo, output int hi);
    lo = 255; hi = 0;
    for (int dy = -2; dy <= 2; dy++)
      for (int dx = -2; dx <= 2; dx++) begin
        int q = img[cl(r + dy, H - 1)][cl(c + dx, W - 1)];
        if (q < lo) lo = q;
        if (q > hi) hi = q;
      end
  endtask

  task automatic judge(input vec_t v, input int idx, input int got);
    int r = idx / W, c = idx % W, e, lo, hi;
    win_range(r, c, lo, hi);
    chk(got >= lo && got <= hi, "R6 window bound", got, lo);
    if (v.kind == 3'd0)
      chk(got == img[r][c], "R4 flat passthrough", got, img[r][c]);
    else if (v.kind == 3'd1 || v.kind == 3'd2)
      chk(got - img[r][c] <= 1 && img[r][c] - got <= 1, "R5 step edge kept", got, img[r][c]);
    else begin
      e = ref_px(r, c);
      if (r < 2 || r >= H - 2 || c < 2 || c >= W - 2)
        chk(got - e <= 1 && e - got <= 1, "R7 border replicate", got, e);
      else
        chk(got - e <= 1 && e - got <= 1, "R8 weighted mean", got, e);
    end
  endtask

  task automatic run_frame(input vec_t v);
    int sent = 0, got = 0;
    bit last_fire = 0, hold_prev = 0, prev_ir = 1, prev_ov = 0;
    logic [7:0] hold_val = '0;
    while (got < NPIX && !timed_out) begin
      @(negedge clk);
      cyc++;
      if (cyc > LIMIT) begin
        timed_out = 1'b1;
        chk(1'b0, "R3 watchdog expired", got, NPIX);
      end else begin
        if (hold_prev) chk(out_valid && out_pixel == hold_val, "R1 output held", int'(out_pixel), int'(hold_val));
        if (out_valid && !prev_ov) chk(!prev_ir, "R2 ready low in division", int'(prev_ir), 0);
        if (last_fire) sent++;
        in_valid = (sent < NPIX) && (rbit() | rbit());
        in_pixel = (sent < NPIX) ? 8'(img[sent / W][sent % W]) : 8'h00;
        last_fire = in_valid && in_ready;
        out_ready = rbit() | rbit();
        if (out_valid && out_ready) begin
          judge(v, got, int'(out_pixel));
          got++;
        end
        hold_prev = out_valid && !out_ready;
        hold_val = out_pixel;
        prev_ir = in_ready;
        prev_ov = out_valid;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(got == NPIX, "R3 frame length", got, NPIX);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9 reset out_valid", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 idle out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R9 idle in_ready", int'(in_ready), 1);

    // table of frames, run back to back
    foreach (VECS[i]) begin
      if (!timed_out) begin
        fill(VECS[i]);
        run_frame(VECS[i]);
      end
    end

    // directed: after the last frame no stray output appears (R3)
    out_ready = 1'b1;
    repeat (60) @(negedge clk);
    chk(out_valid == 1'b0, "R3 no extra output", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 ready for next frame", int'(in_ready), 1);

    // directed: reset returns to idle state (R9)
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R9 re-reset idle", int'({out_valid, in_ready}), 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule